// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block caches recently used virtual-to-physical page mappings for a processor's memory pipeline. Each lookup presents a virtual address, the kind of access (read, write or instruction fetch) and the identifier of the address space that is running. Within the same cycle the block answers with a hit or miss flag, a fault flag and the translated physical address. Pages are 4 KiB, so the low 12 address bits pass through unchanged and only the page number is replaced.

The buffer does not walk page tables. On a miss it raises neither an address nor a fault, and leaves the refill to an external walker. The walker returns the mapping through the fill port. Every cached mapping carries a context tag, so switching between address spaces does not require emptying the buffer. Every mapping also carries a present bit and separate read, write and execute permissions, and these are checked on each lookup. Software-driven maintenance reaches the block through three commands: drop one page in every context, drop every entry, or drop all entries of one context.

Top module: `ctx_tlb`

## Requirements
- R1: After reset no entry is valid, and every lookup misses.
- R2: A lookup whose page number and context both match a valid, present entry that permits the access gives lk_hit=1, lk_fault=0 and lk_paddr = {entry physical page, lk_vaddr[11:0]} in the same cycle.
- R3: A lookup that matches no valid entry gives lk_hit=0, lk_fault=0 and lk_paddr=0.
- R4: A lookup that matches an entry whose present bit is 0 gives lk_hit=1, lk_fault=1 and lk_paddr=0, whatever the permissions.
- R5: lk_acc encodes 2'b00 read, 2'b01 write, 2'b10 execute and 2'b11 reserved. A matching present entry whose matching permission bit is 0, or any reserved access, gives lk_hit=1, lk_fault=1 and lk_paddr=0.
- R6: A lookup matches only entries whose context tag equals lk_ctx. Entries of other contexts stay cached and still translate when their context returns.
- R7: A fill is visible from the cycle after its clock edge. A fill whose page and context are already cached overwrites that entry rather than adding a second copy.
- R8: A fill of a new mapping takes the lowest-numbered invalid entry. When every entry is valid, it takes the entry named by a round-robin pointer. The pointer starts at entry 0 after reset and moves by one after each fill that uses it.
- R9: An invalidate-page command removes, at the next edge, every entry with that virtual page number in every context.
- R10: A flush-all command removes every entry at the next edge. A fill in the same cycle is discarded.
- R11: A flush-context command removes only the entries tagged with the given context.
- R12: A fill in the same cycle as an invalidate of the same page, or as a flush of the same context, is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vaddr | input | 48 | Lookup virtual address |
| lk_acc | input | 2 | Lookup access kind (00 read, 01 write, 10 execute, 11 reserved) |
| lk_ctx | input | 12 | Current address-space context |
| lk_paddr | output | 40 | Translated physical address, zero unless the lookup is a clean hit |
| lk_hit | output | 1 | A matching entry exists |
| lk_fault | output | 1 | Match, but not present or access not permitted |
| fill_en | input | 1 | Install a mapping at the next edge |
| fill_vpn | input | 36 | Virtual page number to install |
| fill_ctx | input | 12 | Context tag to install |
| fill_ppn | input | 28 | Physical page number to install |
| fill_present | input | 1 | Present bit of the mapping |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| fill_ex | input | 1 | Execute permitted |
| inv_en | input | 1 | Invalidate one page in all contexts |
| inv_vpn | input | 36 | Page number to invalidate |
| flush_all | input | 1 | Remove every entry |
| fctx_en | input | 1 | Remove the entries of one context |
| fctx_id | input | 12 | Context to remove |

## Verification
The hardest state to reach from the ports is a full buffer in which the round-robin pointer, rather than a free slot, picks the victim. Reaching it needs sixteen distinct fills with no invalidation between them. The stimulus builds that state on purpose: it refills one cached page first, so that a duplicate created by a faulty refill would show up as a hit that survives eviction. It then fills past capacity and checks which pages are gone. Collisions between fill and invalidate or flush in the same cycle are driven on purpose. They also come up often in a long random phase over a narrow range of pages and contexts, and a behavioural model compares the outputs on every clock throughout.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the context-tagged TLB.
// Assumes access kinds fit in two bits; code 3 is reserved and always faults.
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_t;

    typedef struct packed {
        logic present;
        logic rd;
        logic wr;
        logic ex;
    } attr_t;

endpackage

// File: rtl/tlb_entry_array.sv
`timescale 1ns/1ps
// Module: tlb_entry_array
// Holds N mapping entries and compares them against the lookup key and the
// fill key. Clears and writes happen at the clock edge, and a write to a slot
// overrides a clear of the same slot. Assumes fill_slot is valid whenever
// fill_go is high, and that at most one entry matches any page/context pair.
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int VPN_W = 36,
    parameter int PPN_W = 28,
    parameter int CTX_W = 12,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [CTX_W-1:0] lk_ctx,
    input  logic             fill_go,
    input  logic [IDX_W-1:0] fill_slot,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [CTX_W-1:0] fill_ctx,
    input  logic [PPN_W-1:0] fill_ppn,
    input  attr_t            fill_attr,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush_all,
    input  logic             fctx_en,
    input  logic [CTX_W-1:0] fctx_id,
    output logic [N-1:0]     hit_vec,
    output logic [N-1:0]     fill_hit_vec,
    output logic [N-1:0]     valid_vec,
    output logic [PPN_W-1:0] rd_ppn,
    output attr_t            rd_attr
);

    logic             valid_q [N];
    logic [VPN_W-1:0] vpn_q   [N];
    logic [CTX_W-1:0] ctx_q   [N];
    logic [PPN_W-1:0] ppn_q   [N];
    attr_t            attr_q  [N];
    logic [N-1:0]     kill;

    // Per-entry comparators for lookup, fill and the removal commands.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign valid_vec[g]    = valid_q[g];
        assign hit_vec[g]      = valid_q[g] && (vpn_q[g] == lk_vpn) && (ctx_q[g] == lk_ctx);
        assign fill_hit_vec[g] = valid_q[g] && (vpn_q[g] == fill_vpn) && (ctx_q[g] == fill_ctx);
        assign kill[g]         = flush_all
                               || (inv_en && (vpn_q[g] == inv_vpn))
                               || (fctx_en && (ctx_q[g] == fctx_id));
    end

    // Read mux: OR-reduce the payload of the single matching entry.
    always_comb begin
        rd_ppn  = '0;
        rd_attr = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                rd_ppn  = rd_ppn | ppn_q[i];
                rd_attr = rd_attr | attr_q[i];
            end
        end
    end

    // Entry storage: removals first, then the fill overrides its own slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                valid_q[i] <= 1'b0;
                vpn_q[i]   <= '0;
                ctx_q[i]   <= '0;
                ppn_q[i]   <= '0;
                attr_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (kill[i]) begin
                    valid_q[i] <= 1'b0;
                end
                if (fill_go && (fill_slot == IDX_W'(i))) begin
                    valid_q[i] <= 1'b1;
                    vpn_q[i]   <= fill_vpn;
                    ctx_q[i]   <= fill_ctx;
                    ppn_q[i]   <= fill_ppn;
                    attr_q[i]  <= fill_attr;
                end
            end
        end
    end

endmodule

// File: rtl/tlb_victim_sel.sv
`timescale 1ns/1ps
// Module: tlb_victim_sel
// Picks the slot a fill writes to. An existing copy of the same page and
// context comes first, then the lowest invalid slot, then a round-robin
// pointer. The pointer moves only when it was used by an accepted fill.
module tlb_victim_sel #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_vec,
    input  logic [N-1:0]     fill_hit_vec,
    input  logic             fill_go,
    output logic [IDX_W-1:0] slot
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] free_idx;
    logic             match_any;
    logic             full;

    // Slot choice: same key, else lowest free, else pointer.
    always_comb begin
        match_any = |fill_hit_vec;
        full      = &valid_vec;
        match_idx = '0;
        free_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (fill_hit_vec[i]) begin
                match_idx = IDX_W'(i);
            end
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
            end
        end
        if (match_any) begin
            slot = match_idx;
        end else if (!full) begin
            slot = free_idx;
        end else begin
            slot = rr_q;
        end
    end

    // Round-robin pointer: advance after a fill that evicted by pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill_go && !match_any && full) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_perm_check.sv
`timescale 1ns/1ps
// Module: tlb_perm_check
// Decides whether a matching entry faults: not present, a missing
// permission for the requested access, or the reserved access code.
// Purely combinational; gives no fault when there is no match.
module tlb_perm_check
    import tlb_pkg::*;
(
    input  logic  hit,
    input  attr_t attr,
    input  acc_t  acc,
    output logic  fault
);

    logic allowed;

    // Permission lookup for the access kind.
    always_comb begin
        unique case (acc)
            ACC_READ:  allowed = attr.rd;
            ACC_WRITE: allowed = attr.wr;
            ACC_EXEC:  allowed = attr.ex;
            default:   allowed = 1'b0;
        endcase
        fault = hit && (!attr.present || !allowed);
    end

endmodule

// File: rtl/ctx_tlb.sv
`timescale 1ns/1ps
// Module: ctx_tlb (top)
// Fully associative TLB with context tags and per-page permissions.
// Lookup is combinational. Fill, page invalidate, context flush and full
// flush take effect at the next clock edge. A fill that collides with a
// removal of the same page, the same context, or everything is dropped.
// Assumes 4 KiB pages (OFS_W = 12) and an external walker that services misses.
module ctx_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 36,
    parameter int PPN_W   = 28,
    parameter int CTX_W   = 12,
    parameter int OFS_W   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [VPN_W+OFS_W-1:0] lk_vaddr,
    input  logic [1:0]             lk_acc,
    input  logic [CTX_W-1:0]       lk_ctx,
    output logic [PPN_W+OFS_W-1:0] lk_paddr,
    output logic                   lk_hit,
    output logic                   lk_fault,
    input  logic                   fill_en,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [CTX_W-1:0]       fill_ctx,
    input  logic [PPN_W-1:0]       fill_ppn,
    input  logic                   fill_present,
    input  logic                   fill_rd,
    input  logic                   fill_wr,
    input  logic                   fill_ex,
    input  logic                   inv_en,
    input  logic [VPN_W-1:0]       inv_vpn,
    input  logic                   flush_all,
    input  logic                   fctx_en,
    input  logic [CTX_W-1:0]       fctx_id
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fill_match;
    logic [ENTRIES-1:0] valid_vec;
    logic [PPN_W-1:0]   rd_ppn;
    attr_t              rd_attr;
    attr_t              fill_attr;
    logic [IDX_W-1:0]   fill_slot;
    logic               fill_go;
    logic               fault;

    assign lk_vpn    = lk_vaddr[VPN_W+OFS_W-1:OFS_W];
    assign fill_attr = '{present: fill_present, rd: fill_rd, wr: fill_wr, ex: fill_ex};

    // Fill acceptance: any same-cycle removal touching the fill key wins.
    always_comb begin
        fill_go = fill_en
               && !flush_all
               && !(inv_en && (inv_vpn == fill_vpn))
               && !(fctx_en && (fctx_id == fill_ctx));
    end

    tlb_entry_array #(
        .N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W)
    ) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_vpn       (lk_vpn),
        .lk_ctx       (lk_ctx),
        .fill_go      (fill_go),
        .fill_slot    (fill_slot),
        .fill_vpn     (fill_vpn),
        .fill_ctx     (fill_ctx),
        .fill_ppn     (fill_ppn),
        .fill_attr    (fill_attr),
        .inv_en       (inv_en),
        .inv_vpn      (inv_vpn),
        .flush_all    (flush_all),
        .fctx_en      (fctx_en),
        .fctx_id      (fctx_id),
        .hit_vec      (lk_match),
        .fill_hit_vec (fill_match),
        .valid_vec    (valid_vec),
        .rd_ppn       (rd_ppn),
        .rd_attr      (rd_attr)
    );

    tlb_victim_sel #(.N(ENTRIES)) u_victim (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_vec    (valid_vec),
        .fill_hit_vec (fill_match),
        .fill_go      (fill_go),
        .slot         (fill_slot)
    );

    tlb_perm_check u_perm (
        .hit   (lk_hit),
        .attr  (rd_attr),
        .acc   (acc_t'(lk_acc)),
        .fault (fault)
    );

    // Output formation: address only on a clean hit, offset passes through.
    always_comb begin
        lk_hit   = |lk_match;
        lk_fault = fault;
        lk_paddr = (lk_hit && !fault) ? {rd_ppn, lk_vaddr[OFS_W-1:0]} : '0;
    end

endmodule

// File: rtl/tlb_chk.sv
`timescale 1ns/1ps
// Module: tlb_chk
// Protocol checker for ctx_tlb, attached by bind. Watches the lookup
// outputs and the entry state the array drives.
module tlb_chk #(
    parameter int N     = 16,
    parameter int OFS_W = 12,
    parameter int PA_W  = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OFS_W-1:0] lk_ofs,
    input logic [PA_W-1:0]  lk_paddr,
    input logic             lk_hit,
    input logic             lk_fault,
    input logic             flush_all,
    input logic [N-1:0]     valid_vec,
    input logic [N-1:0]     hit_vec
);

    // R4
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    // R3
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0) && !lk_fault);

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !lk_fault) |-> (lk_paddr[OFS_W-1:0] == lk_ofs));

    // R5
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_paddr == '0));

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0));

    // R7
    no_duplicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

bind ctx_tlb tlb_chk #(
    .N(ENTRIES), .OFS_W(OFS_W), .PA_W(PPN_W + OFS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_ofs    (lk_vaddr[OFS_W-1:0]),
    .lk_paddr  (lk_paddr),
    .lk_hit    (lk_hit),
    .lk_fault  (lk_fault),
    .flush_all (flush_all),
    .valid_vec (valid_vec),
    .hit_vec   (lk_match)
);

// File: tb/test_ctx_tlb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of ctx_tlb, compared on every clock.
module test_ctx_tlb;

    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic [11:0] lk_ctx = '0;
    logic [39:0] lk_paddr;
    logic        lk_hit, lk_fault;
    logic        fill_en = 0;
    logic [35:0] fill_vpn = '0;
    logic [11:0] fill_ctx = '0;
    logic [27:0] fill_ppn = '0;
    logic        fill_present = 0, fill_rd = 0, fill_wr = 0, fill_ex = 0;
    logic        inv_en = 0;
    logic [35:0] inv_vpn = '0;
    logic        flush_all = 0;
    logic        fctx_en = 0;
    logic [11:0] fctx_id = '0;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Reference state
    bit          m_v   [NE];
    logic [35:0] m_vpn [NE];
    logic [11:0] m_ctx [NE];
    logic [27:0] m_ppn [NE];
    bit          m_p [NE], m_r [NE], m_w [NE], m_x [NE];
    int          m_rr;

    always #2.5 clk = ~clk;

    ctx_tlb i_ctx_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vaddr(lk_vaddr), .lk_acc(lk_acc), .lk_ctx(lk_ctx),
        .lk_paddr(lk_paddr), .lk_hit(lk_hit), .lk_fault(lk_fault),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ctx(fill_ctx),
        .fill_ppn(fill_ppn), .fill_present(fill_present),
        .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_ex(fill_ex),
        .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_all(flush_all),
        .fctx_en(fctx_en), .fctx_id(fctx_id)
    );

    task automatic model_reset();
        for (int i = 0; i < NE; i++) m_v[i] = 0;
        m_rr = 0;
    endtask

    task automatic model_update();
        bit go;
        int slot;
        go = fill_en && !flush_all && !(inv_en && inv_vpn == fill_vpn)
             && !(fctx_en && fctx_id == fill_ctx);
        slot = -1;
        for (int i = 0; i < NE; i++)
            if (m_v[i] && m_vpn[i] == fill_vpn && m_ctx[i] == fill_ctx) slot = i;
        if (slot < 0)
            for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) slot = i;
        if (slot < 0 && go) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % NE;
        end
        for (int i = 0; i < NE; i++)
            if (flush_all || (inv_en && m_vpn[i] == inv_vpn) || (fctx_en && m_ctx[i] == fctx_id))
                m_v[i] = 0;
        if (go) begin
            m_v[slot] = 1; m_vpn[slot] = fill_vpn; m_ctx[slot] = fill_ctx;
            m_ppn[slot] = fill_ppn; m_p[slot] = fill_present;
            m_r[slot] = fill_rd; m_w[slot] = fill_wr; m_x[slot] = fill_ex;
        end
    endtask

    // One cycle: compare lookup outputs, advance model at the edge, clear commands.
    task automatic step(input string tag);
        bit e_hit, e_fault, ok;
        logic [39:0] e_pa;
        #1;
        e_hit = 0; e_fault = 0; e_pa = '0;
        for (int i = 0; i < NE; i++) begin
            if (m_v[i] && m_vpn[i] == lk_vaddr[47:12] && m_ctx[i] == lk_ctx) begin
                e_hit = 1;
                case (lk_acc)
                    2'b00: ok = m_r[i];
                    2'b01: ok = m_w[i];
                    2'b10: ok = m_x[i];
                    default: ok = 0;
                endcase
                e_fault = !m_p[i] || !ok;
                e_pa = e_fault ? '0 : {m_ppn[i], lk_vaddr[11:0]};
            end
        end
        vectors++;
        if (lk_hit !== e_hit || lk_fault !== e_fault || lk_paddr !== e_pa) begin
            miscompares++;
            $display("FAIL %s: hit/fault/paddr got %0b/%0b/%h exp %0b/%0b/%h",
                     tag, lk_hit, lk_fault, lk_paddr, e_hit, e_fault, e_pa);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
        fill_en = 0; inv_en = 0; flush_all = 0; fctx_en = 0;
    endtask

    task automatic fill(input logic [35:0] v, input logic [11:0] c, input logic [27:0] p,
                        input bit pr, input bit r, input bit w, input bit x);
        fill_en = 1; fill_vpn = v; fill_ctx = c; fill_ppn = p;
        fill_present = pr; fill_rd = r; fill_wr = w; fill_ex = x;
    endtask

    task automatic look(input logic [35:0] v, input logic [11:0] off,
                        input logic [1:0] a, input logic [11:0] c);
        lk_vaddr = {v, off}; lk_acc = a; lk_ctx = c;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();

        // R1: empty after reset
        look(36'h0, 12'h123, 2'b00, 12'd0); step("R1");
        look(36'hABCDE, 12'hFFF, 2'b10, 12'd1); step("R1");

        // R7: fill not visible in its own cycle; R3 miss
        fill(36'h55, 12'd1, 28'h1234, 1, 1, 0, 0);
        look(36'h55, 12'h0A0, 2'b00, 12'd1); step("R7");
        step("R2");                               // read hit
        look(36'h55, 12'h0A0, 2'b01, 12'd1); step("R5");   // write denied
        look(36'h55, 12'h0A0, 2'b10, 12'd1); step("R5");   // exec denied
        look(36'h55, 12'h0A0, 2'b11, 12'd1); step("R5");   // reserved
        look(36'h55, 12'h0A0, 2'b00, 12'd2); step("R6");   // other context
        look(36'h56, 12'h0A0, 2'b00, 12'd1); step("R3");

        // R7: refill same key replaces
        fill(36'h55, 12'd1, 28'h0BEEF, 1, 1, 1, 1);
        look(36'h55, 12'h7FF, 2'b01, 12'd1); step("R7");
        step("R7");

        // R8: fill to capacity then past it
        for (int i = 0; i < 15; i++) begin
            fill(36'd100 + 36'(i), 12'd1, 28'd500 + 28'(i), 1, 1, 1, 0);
            step("R8");
        end
        fill(36'h999, 12'd1, 28'h777, 1, 1, 0, 0);
        look(36'h55, 12'h001, 2'b00, 12'd1); step("R8");
        step("R8");                                       // page 0x55 evicted
        fill(36'h998, 12'd1, 28'h778, 1, 1, 0, 0);
        look(36'd100, 12'h002, 2'b00, 12'd1); step("R8");
        step("R8");                                       // first of 100.. evicted
        look(36'd101, 12'h002, 2'b00, 12'd1); step("R8");

        // R4: not present
        flush_all = 1; step("R10");
        fill(36'h77, 12'd1, 28'h42, 0, 1, 1, 1); step("R4");
        look(36'h77, 12'h010, 2'b00, 12'd1); step("R4");

        // R6: same page, two contexts
        fill(36'hC0, 12'd5, 28'h505, 1, 1, 1, 1); step("R6");
        fill(36'hC0, 12'd6, 28'h606, 1, 1, 1, 1); step("R6");
        look(36'hC0, 12'h100, 2'b00, 12'd5); step("R6");
        look(36'hC0, 12'h100, 2'b00, 12'd6); step("R6");

        // R11: flush context 5 only
        fctx_en = 1; fctx_id = 12'd5; step("R11");
        look(36'hC0, 12'h100, 2'b00, 12'd5); step("R11");
        look(36'hC0, 12'h100, 2'b00, 12'd6); step("R11");

        // R9: invalidate page across contexts
        fill(36'hC0, 12'd7, 28'h707, 1, 1, 0, 0); step("R9");
        inv_en = 1; inv_vpn = 36'hC0; step("R9");
        look(36'hC0, 12'h100, 2'b00, 12'd6); step("R9");
        look(36'hC0, 12'h100, 2'b00, 12'd7); step("R9");

        // R12: fill against same-page invalidate, same-context flush
        fill(36'hD0, 12'd2, 28'h808, 1, 1, 1, 1);
        inv_en = 1; inv_vpn = 36'hD0; step("R12");
        look(36'hD0, 12'h000, 2'b00, 12'd2); step("R12");
        fill(36'hE0, 12'd3, 28'h909, 1, 1, 1, 1);
        fctx_en = 1; fctx_id = 12'd3; step("R12");
        look(36'hE0, 12'h000, 2'b00, 12'd3); step("R12");

        // R10: flush with fill
        fill(36'hF0, 12'd1, 28'h111, 1, 1, 1, 1); step("R10");
        fill(36'hF1, 12'd1, 28'h112, 1, 1, 1, 1);
        flush_all = 1;
        look(36'hF0, 12'h000, 2'b00, 12'd1); step("R10");
        step("R10");
        look(36'hF1, 12'h000, 2'b00, 12'd1); step("R10");

        // Random collisions over a narrow key space
        for (int n = 0; n < 4000; n++) begin
            look(36'($urandom_range(0, 23)), 12'($urandom), 2'($urandom), 12'($urandom_range(0, 3)));
            if ($urandom_range(0, 99) < 45)
                fill(36'($urandom_range(0, 23)), 12'($urandom_range(0, 3)), 28'($urandom),
                     1'($urandom_range(0, 7) != 0), 1'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 99) < 6) begin inv_en = 1; inv_vpn = 36'($urandom_range(0, 23)); end
            if ($urandom_range(0, 99) < 3) begin fctx_en = 1; fctx_id = 12'($urandom_range(0, 3)); end
            if ($urandom_range(0, 999) < 4) flush_all = 1;
            step("R2/random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule